// File: doc/BRIEF.md
# Fractional SPI Serial Clock Generator

This block turns a fast reference clock into an SPI serial clock and the two data strobes that go with it. Instead of dividing by an integer, it adds a per-profile frequency word into a phase accumulator every reference cycle. Each time the accumulator passes its modulus of 2048, the internal clock phase flips. The serial clock therefore toggles on average `word / 2048` times per reference cycle. Fractional words give fractional rates, with one cycle of jitter between edges. An optional loop reset trades that jitter for a rate rounded to whole reference cycles.

The transfer engine selects a profile and raises `en` for the length of a transfer. Outside this block it uses `launch` to drive the next data bit and `latch` to sample the incoming one. Each profile decides which clock edge (rising or falling) carries the launch strobe. The latch strobe always takes the other edge. A global polarity bit sets the level the clock rests at. A global gate bit freezes the clock whenever no slave select is active. A small write/read register port holds a clock-control word and a signal-control word for each profile, plus one global word.

Top module: `spi_sck_gen`

## Requirements
- R1: After reset `sck` is 0, `launch` and `latch` are 0, and every register reads back as 0.
- R2: Register map (word address on `reg_addr`). Address 0 is the global word: bit 16 gate, bit 17 clock polarity, bit 18 idle data level. Address 2p+2 is the clock-control word of profile p: bits 15:0 are stored, bits 13:0 are the frequency field, bit 14 doubles the step, bit 15 enables the loop reset. Address 2p+3 is the signal-control word of profile p: bit 12 latch-on-rising, bit 13 launch-on-rising, bit 16 async input path. Unlisted bits read back as 0.
- R3: While `en` is high, the step (the frequency field, capped at 2048) is added to an accumulator that starts at 0. Every time the sum reaches 2048, `sck` toggles in the reference cycle where that happens and 2048 is subtracted. A step of 512 toggles `sck` once every 4 cycles.
- R4: With bit 14 set, the step is twice the frequency field, capped at 2048.
- R5: Without loop reset, the fraction carries forward: over N cycles from enable there are exactly floor(N·step/2048) toggles.
- R6: With bit 15 set, the accumulator clears to 0 on every toggle, so toggles repeat every ceil(2048/step) cycles.
- R7: `sck` rests at the value of the polarity bit whenever it is not toggling from an enabled profile.
- R8: Bit 13 of the signal-control word puts the launch strobe on rising `sck` edges. When bit 13 is clear, the launch strobe is on falling edges. The latch strobe is on the other edge. Each strobe is one cycle wide and coincides with the `sck` change.
- R9: If the first `sck` edge after enable is a latch edge, a single launch strobe appears in the first cycle after `en` rises. Otherwise there is no extra strobe.
- R10: One cycle after `en` drops, `sck` is at its rest level, no strobe is present, and the accumulator is 0. A later enable times its edges like a fresh start.
- R11: A step of 0 keeps `sck` at rest and produces no strobes.
- R12: With the gate bit set and `ss_active` low, the accumulator and `sck` hold their values. They resume from where they stopped once `ss_active` rises.
- R13: `prof_sel` chooses which profile's words drive the clock and strobes.
- R14: `mosi_idle` follows global bit 18, and `async_path` follows bit 16 of the selected profile's signal-control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Engine enable for clock generation |
| ss_active | input | 1 | High while any slave select is asserted |
| prof_sel | input | PW | Active profile index |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sck | output | 1 | Serial clock |
| launch | output | 1 | Data launch strobe |
| latch | output | 1 | Data latch strobe |
| mosi_idle | output | 1 | Idle level for the data output |
| async_path | output | 1 | Async input path select of the active profile |

## Verification
The bench uses the default parameters: four profiles, a 16-bit control word and a 12-bit accumulator with a modulus of 2048. It programs two of the four profiles, so the switch to a second profile and the leakage of one profile's settings into another can both be observed. With the 2048 modulus, steps of 512, 768 and 1024 produce short, exact toggle counts. The step of 768 separates the fraction-carrying sequence (24 toggles in 64 cycles) from the loop-reset sequence (21 toggles). The step of 512 puts the first edge at cycle 4, so the enable-time launch strobe appears alone.

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int NPROF = 4,
  parameter int FW    = 16,
  parameter int ACC_W = 12,
  parameter int PW    = (NPROF > 1) ? $clog2(NPROF) : 1,
  parameter int AW    = $clog2(2 * NPROF + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ss_active,
  input  logic [PW-1:0] prof_sel,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          sck,
  output logic          launch,
  output logic          latch,
  output logic          mosi_idle,
  output logic          async_path
);
  localparam int MOD     = 2 ** (ACC_W - 1);
  localparam int B_X2    = FW - 2;
  localparam int B_LOOP  = FW - 1;
  localparam int B_CAPR  = 12;
  localparam int B_LNCR  = 13;
  localparam int B_ASYNC = 16;
  localparam int B_GATE  = 16;
  localparam int B_CPOL  = 17;
  localparam int B_MIDLE = 18;

  logic [FW-1:0] clkw [NPROF];
  logic [2:0]    sigw [NPROF];
  logic [2:0]    glob;

  logic unused_w;
  assign unused_w = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob <= '0;
      for (int p = 0; p < NPROF; p++) begin
        clkw[p] <= '0;
        sigw[p] <= '0;
      end
    end else if (reg_we) begin
      if (reg_addr == '0)
        glob <= {reg_wdata[B_MIDLE], reg_wdata[B_CPOL], reg_wdata[B_GATE]};
      for (int p = 0; p < NPROF; p++) begin
        if (reg_addr == AW'(2 * p + 2)) clkw[p] <= reg_wdata[FW-1:0];
        if (reg_addr == AW'(2 * p + 3))
          sigw[p] <= {reg_wdata[B_ASYNC], reg_wdata[B_LNCR], reg_wdata[B_CAPR]};
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) begin
      reg_rdata[B_GATE]  = glob[0];
      reg_rdata[B_CPOL]  = glob[1];
      reg_rdata[B_MIDLE] = glob[2];
    end
    for (int p = 0; p < NPROF; p++) begin
      if (reg_addr == AW'(2 * p + 2)) reg_rdata[FW-1:0] = clkw[p];
      if (reg_addr == AW'(2 * p + 3)) begin
        reg_rdata[B_CAPR]  = sigw[p][0];
        reg_rdata[B_LNCR]  = sigw[p][1];
        reg_rdata[B_ASYNC] = sigw[p][2];
      end
    end
  end

  logic [FW-1:0]    cw;
  logic [FW-2:0]    raw;
  logic [ACC_W-1:0] step, acc, sum;
  logic             lp, cpol, lr, gated, adv, carry, tog, ph, en_d, lvl_n, is_launch, need;

  assign cw    = clkw[prof_sel];
  assign lp    = cw[B_LOOP];
  assign cpol  = glob[1];
  assign lr    = sigw[prof_sel][1];
  assign raw   = cw[B_X2] ? {cw[FW-3:0], 1'b0} : {1'b0, cw[FW-3:0]};
  assign step  = (raw > (FW-1)'(MOD)) ? ACC_W'(MOD) : raw[ACC_W-1:0];
  assign sum   = acc + step;
  assign carry = sum >= ACC_W'(MOD);
  assign gated = glob[0] & ~ss_active;
  assign adv   = en & (step != '0) & ~gated;
  assign tog   = adv & carry;
  assign lvl_n = ph ^ tog ^ cpol;
  assign is_launch = (lvl_n == lr);
  assign need  = (lr == cpol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; ph <= 1'b0; en_d <= 1'b0; launch <= 1'b0; latch <= 1'b0;
    end else begin
      en_d   <= en;
      launch <= (tog & is_launch) | (adv & ~en_d & need);
      latch  <= tog & ~is_launch;
      if (!en) begin
        acc <= '0;
        ph  <= 1'b0;
      end else if (adv) begin
        acc <= carry ? (lp ? '0 : sum - ACC_W'(MOD)) : sum;
        ph  <= ph ^ tog;
      end
    end
  end

  assign sck        = ph ^ cpol;
  assign mosi_idle  = glob[2];
  assign async_path = sigw[prof_sel][2];
endmodule

module spi_sck_gen_chk #(
  parameter int ACC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             ss_active,
  input logic             gated,
  input logic [ACC_W-1:0] step,
  input logic [ACC_W-1:0] acc,
  input logic             lp,
  input logic             tog,
  input logic             ph,
  input logic             launch,
  input logic             latch
);
  localparam int MOD = 2 ** (ACC_W - 1);

  AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    acc < ACC_W'(MOD)); // R3
  AST_LOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lp && tog) |=> acc == '0); // R6
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ph && acc == '0 && !launch && !latch)); // R10
  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step == '0) |=> ($stable(ph) && !launch && !latch)); // R11
  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gated && !ss_active) |=> ($stable(ph) && $stable(acc))); // R12
  AST_LATCH_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> ph != $past(ph)); // R8
endmodule

bind spi_sck_gen spi_sck_gen_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ss_active(ss_active), .gated(gated),
  .step(step), .acc(acc), .lp(lp), .tog(tog), .ph(ph),
  .launch(launch), .latch(latch)
);

// File: tb/spi_sck_gen_test.sv
module spi_sck_gen_test;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, ss_active = 1'b0, reg_we = 1'b0;
  logic [1:0]  prof_sel = '0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sck, launch, latch, mosi_idle, async_path;
  int errs = 0, checks = 0;

  spi_sck_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .ss_active(ss_active), .prof_sel(prof_sel),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .launch(launch), .latch(latch), .mosi_idle(mosi_idle), .async_path(async_path)
  );

  always #4 clk = ~clk;

  initial begin
    #2000000;
    checks++; errs++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 4'(a); #1; d = reg_rdata;
  endtask

  task automatic run(input int n, output int t, output int l, output int c);
    logic prev;
    prev = sck; t = 0; l = 0; c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sck != prev) t++;
      if (launch) l++;
      if (latch) c++;
      prev = sck;
    end
  endtask

  task automatic stop(input logic idle);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R10 sck rest after disable", sck, idle);
    chk("R10 no strobe after disable", launch | latch, 0);
  endtask

  task automatic count_case(input string tag, input logic [31:0] cw, input int n, input int exp_t);
    int t, l, c;
    wr(2, cw); wr(3, 32'h1000);
    @(negedge clk); en = 1'b1;
    run(n, t, l, c);
    chk(tag, t, exp_t);
    stop(1'b0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 sck", sck, 0);
    chk("R1 strobes", launch | latch, 0);
    rd(0, d); chk("R1 global", d, 0);
    rd(2, d); chk("R1 clock word", d, 0);
    rd(3, d); chk("R1 signal word", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R2 clock word mask", d, 32'h0000_FFFF);
    wr(3, 32'hFFFF_FFFF); rd(3, d); chk("R2 signal word mask", d, 32'h0001_3000);
    wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R2 global mask", d, 32'h0007_0000);
    wr(0, 0); wr(2, 0); wr(3, 0);
  endtask

  task automatic t_mode0;
    logic s [17];
    logic la [17];
    logic lt [17];
    wr(2, 512); wr(3, 32'h1000);
    for (int pass = 0; pass < 2; pass++) begin
      @(negedge clk); en = 1'b1;
      for (int i = 1; i <= 16; i++) begin
        @(negedge clk); s[i] = sck; la[i] = launch; lt[i] = latch;
      end
      chk("R9 launch one cycle after enable", la[1], 1);
      chk("R3 sck low before first edge", s[3], 0);
      chk("R3 first rising edge at cycle 4", s[4], 1);
      chk("R8 latch on rising edge", lt[4], 1);
      chk("R8 launch on falling edge", la[8], 1);
      chk("R8 no launch on rising edge", la[4] | la[12], 0);
      chk("R3 second rising edge at cycle 12", s[12] & ~s[11], 1);
      stop(1'b0);
    end
  endtask

  task automatic t_counts;
    count_case("R3 step 1024 toggles", 32'd1024, 64, 32);
    count_case("R3 step 2048 toggles every cycle", 32'd2048, 20, 20);
    count_case("R4 doubled step 512 toggles", 32'h4200, 64, 32);
    count_case("R4 doubled step capped at 2048", 32'h4600, 20, 20);
    count_case("R5 fractional step 768 toggles", 32'd768, 64, 24);
    count_case("R6 loop reset step 768 toggles", 32'h8300, 64, 21);
  endtask

  task automatic t_polarity;
    int t, l, c;
    logic s4, c4, l1, l8, s8;
    wr(0, 32'h0002_0000);
    @(negedge clk);
    chk("R7 rest level high", sck, 1);
    wr(2, 512); wr(3, 32'h2000);
    @(negedge clk); en = 1'b1;
    @(negedge clk); l1 = launch;
    @(negedge clk); @(negedge clk); @(negedge clk); s4 = sck; c4 = latch;
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk); s8 = sck; l8 = launch;
    chk("R9 launch strobe when first edge latches", l1, 1);
    chk("R7 first edge falls from high rest", s4, 0);
    chk("R8 latch on falling edge", c4, 1);
    chk("R8 launch on rising edge", s8 & l8, 1);
    stop(1'b1);
    wr(0, 0);
    @(negedge clk); en = 1'b1;
    run(32, t, l, c);
    chk("R9 no extra launch when first edge launches", l, 4);
    chk("R8 latch count", c, 4);
    stop(1'b0);
  endtask

  task automatic t_zero;
    int t, l, c;
    wr(2, 0); wr(3, 32'h1000);
    @(negedge clk); en = 1'b1;
    run(20, t, l, c);
    chk("R11 zero word no toggles", t, 0);
    chk("R11 zero word no strobes", l + c, 0);
    stop(1'b0);
  endtask

  task automatic t_gate;
    int t, l, c;
    wr(0, 32'h0001_0000); wr(2, 512); wr(3, 32'h1000);
    ss_active = 1'b0;
    @(negedge clk); en = 1'b1;
    run(20, t, l, c);
    chk("R12 gated no toggles", t, 0);
    chk("R12 gated no strobes", l + c, 0);
    ss_active = 1'b1;
    run(3, t, l, c);
    chk("R12 no edge before 4 steps", t, 0);
    run(1, t, l, c);
    chk("R12 resumes from held accumulator", t, 1);
    stop(1'b0);
    ss_active = 1'b0;
    wr(0, 0);
  endtask

  task automatic t_profile;
    int t, l, c;
    wr(2, 512); wr(4, 1024); wr(5, 32'h0001_1000); wr(0, 32'h0004_0000);
    prof_sel = 2'd1;
    @(negedge clk);
    chk("R14 async path of profile 1", async_path, 1);
    chk("R14 idle data level", mosi_idle, 1);
    @(negedge clk); en = 1'b1;
    run(32, t, l, c);
    chk("R13 profile 1 word used", t, 16);
    stop(1'b0);
    prof_sel = 2'd0;
    #1;
    chk("R14 async path of profile 0", async_path, 0);
    @(negedge clk); en = 1'b1;
    run(32, t, l, c);
    chk("R13 profile 0 word used", t, 8);
    stop(1'b0);
    wr(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_mode0;
    t_counts;
    t_polarity;
    t_zero;
    t_gate;
    t_profile;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule